// File: doc/BRIEF.md
# Write Strobe Eye-Centering Engine

This block is a calibration sequencer. It places a write strobe in the middle of the data valid window. It sweeps output-delay tap settings and asks an external pattern checker for a pass or fail verdict after each change. A sweep starts from a set of initial tap values. The left side of the window is found by pushing the data delay (DQ, plus DBI when DBI is enabled) later. The right side is found by pushing the strobe delay (DQS) later. Each side is searched twice: first in coarse 10-tap strides, then, from the last coarse point that passed, in single-tap strides.

When both margins are known, exactly one side is corrected. If the right margin is the larger one, the strobe is pulled earlier and the data lanes go back to their initial taps. If the left margin is the larger one, the data lanes are pushed later and the strobe stays at its initial tap. The block then pulses `done`. `err_code` is zero on success. If a sweep would push a delay past the top tap before any failure is seen, `err_code` holds a code that names the stage that ran out of taps.

A run is triggered by `start` while the block is idle. The initial taps and the DBI enable are captured at that moment. The tap outputs always show the setting under test, or the result once the run is over.

Top module: `wdly_center_top`

## Requirements
- R1: After reset, `done` and `chk_req` are low, `err_code` is 0 and all three tap outputs read 0.
- R2: The left coarse sweep raises the DQ tap above its initial value in 10-tap steps while DQS stays at its initial value. `lmrg_crs` is the last offset that passed, which is 10*floor(W/10) for a left window of W taps.
- R3: After the coarse left failure, the data taps step back 10 and advance one tap at a time. `lmrg_fin` is the last passing offset W.
- R4: The right sweeps move only DQS, coarse then fine. DQ and DBI sit at their initial taps throughout. `rmrg_crs` and `rmrg_fin` follow the same rule as the left margins.
- R5: With `dbi_en`=1 the DBI tap moves by the same offset as DQ, and its initial value also limits the left sweep. With `dbi_en`=0 the DBI tap stays at its initial value and does not limit the sweep.
- R6: If the fine right margin exceeds the fine left margin, `dqs_fin` is the initial DQS minus floor((right-left)/2), clamped at 0. `dq_fin` and `dbi_fin` equal their initial values.
- R7: If the fine left margin exceeds the fine right margin, `dqs_fin` is unchanged. `dq_fin` is the initial DQ plus floor((left-right)/2), and so is `dbi_fin` when DBI is enabled.
- R8: A step that would take a moved tap above 511 ends the run with an error code: 0x37 for the coarse left sweep, 0x38 for fine left, 0x39 for coarse right and 0x3A for fine right. On error all finals equal the initial taps.
- R9: Only one check is outstanding at a time. `chk_req` is a one-cycle pulse, and the taps stay fixed until `chk_ack` arrives. `done` is a one-cycle pulse, and `err_code` is 0 on success.
- R10: With equal fine margins all three finals equal the initial taps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when idle |
| dbi_en | input | 1 | DBI delay follows DQ when high |
| init_dq | input | 9 | Initial DQ tap |
| init_dbi | input | 9 | Initial DBI tap |
| init_dqs | input | 9 | Initial DQS tap |
| chk_req | output | 1 | Pulse: run a pattern check at the current taps |
| chk_ack | input | 1 | Check result valid |
| chk_pass | input | 1 | Check result, 1 = pattern matched |
| dq_tap | output | 9 | DQ delay setting |
| dbi_tap | output | 9 | DBI delay setting |
| dqs_tap | output | 9 | DQS delay setting |
| lmrg_crs | output | 9 | Coarse left margin |
| lmrg_fin | output | 9 | Fine left margin |
| rmrg_crs | output | 9 | Coarse right margin |
| rmrg_fin | output | 9 | Fine right margin |
| dqs_fin | output | 9 | Final DQS tap |
| dq_fin | output | 9 | Final DQ tap |
| dbi_fin | output | 9 | Final DBI tap |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 8 | 0 on success, else the stage code |

## Verification
Some properties are checked by assertions on every cycle:
- the request and done pulse widths;
- the taps holding still while a verdict is pending;
- the data lanes staying at their initial taps during the strobe sweeps;
- DBI tracking or holding against DQ;
- the error code range;
- the strobe never ending above its start on success.

Other behaviour depends on a whole run and only the bench scenarios can show it. This covers the margin values for a given eye width, the truncating half-difference correction, clamping at zero, equal margins, and each of the four out-of-range stages. A one-shot false failure in the checker model is what makes the fine-stage exhaustion cases reachable.

// File: rtl/wdly_pkg.sv
package wdly_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_STEP, ST_REQ, ST_WAIT, ST_FIX, ST_DONE} st_e;
  typedef enum logic [1:0] {PH_LC, PH_LF, PH_RC, PH_RF} ph_e;
  // stage codes are consecutive from this base in phase order
  localparam logic [7:0] ERR_BASE = 8'h37;
endpackage

// File: rtl/wdly_fix.sv
// Computes the one-sided correction from the fine margins.
module wdly_fix #(
  parameter int TW = 9
) (
  input  logic [TW-1:0] lf,
  input  logic [TW-1:0] rf,
  input  logic [TW-1:0] idq,
  input  logic [TW-1:0] idbi,
  input  logic [TW-1:0] idqs,
  input  logic          den,
  output logic [TW-1:0] dqs_o,
  output logic [TW-1:0] dq_o,
  output logic [TW-1:0] dbi_o
);
  logic [TW-1:0] half;

  always_comb begin
    dqs_o = idqs;
    dq_o  = idq;
    dbi_o = idbi;
    half  = '0;
    if (rf > lf) begin
      half  = (rf - lf) >> 1;
      dqs_o = (idqs >= half) ? (idqs - half) : '0;
    end else if (lf > rf) begin
      half = (lf - rf) >> 1;
      dq_o = idq + half;
      if (den) dbi_o = idbi + half;
    end
  end
endmodule

// File: rtl/wdly_tapmux.sv
// Selects the tap settings under test or the final result.
module wdly_tapmux
  import wdly_pkg::*;
#(
  parameter int TW = 9
) (
  input  st_e           st,
  input  ph_e           ph,
  input  logic [TW-1:0] off,
  input  logic [TW-1:0] cdq,
  input  logic [TW-1:0] cdbi,
  input  logic [TW-1:0] cdqs,
  input  logic          cden,
  input  logic [TW-1:0] fdq,
  input  logic [TW-1:0] fdbi,
  input  logic [TW-1:0] fdqs,
  output logic [TW-1:0] dq,
  output logic [TW-1:0] dbi,
  output logic [TW-1:0] dqs,
  output logic          lphase,
  output logic          rphase
);
  logic busy, left;

  assign busy   = (st == ST_STEP) || (st == ST_REQ) || (st == ST_WAIT);
  assign left   = (ph == PH_LC) || (ph == PH_LF);
  assign lphase = busy && left;
  assign rphase = busy && !left;

  always_comb begin
    if (lphase) begin
      dq  = cdq + off;
      dbi = cden ? (cdbi + off) : cdbi;
      dqs = cdqs;
    end else if (rphase) begin
      dq  = cdq;
      dbi = cdbi;
      dqs = cdqs + off;
    end else begin
      dq  = fdq;
      dbi = fdbi;
      dqs = fdqs;
    end
  end
endmodule

// File: rtl/wdly_seq.sv
// Sweep sequencer: stage order, offset stepping, margin capture.
module wdly_seq
  import wdly_pkg::*;
#(
  parameter int TW      = 9,
  parameter int TAP_MAX = 511,
  parameter int CSTEP   = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dbi_en,
  input  logic [TW-1:0] init_dq,
  input  logic [TW-1:0] init_dbi,
  input  logic [TW-1:0] init_dqs,
  input  logic          chk_ack,
  input  logic          chk_pass,
  input  logic [TW-1:0] fix_dqs,
  input  logic [TW-1:0] fix_dq,
  input  logic [TW-1:0] fix_dbi,
  output st_e           st_o,
  output ph_e           ph_o,
  output logic [TW-1:0] off_o,
  output logic [TW-1:0] cap_dq,
  output logic [TW-1:0] cap_dbi,
  output logic [TW-1:0] cap_dqs,
  output logic          cap_den,
  output logic [TW-1:0] lc,
  output logic [TW-1:0] lf,
  output logic [TW-1:0] rc,
  output logic [TW-1:0] rf,
  output logic [TW-1:0] fin_dqs,
  output logic [TW-1:0] fin_dq,
  output logic [TW-1:0] fin_dbi,
  output logic          chk_req,
  output logic          done,
  output logic [7:0]    err_code
);
  localparam int OW = TW + 1;

  st_e           st_q, st_n;
  ph_e           ph_q, ph_n;
  logic [OW-1:0] off_q, off_n, step, nxt, back, lim;
  logic [TW-1:0] lc_n, lf_n, rc_n, rf_n, lhi;
  logic [7:0]    err_n;
  logic          cap_en, fin_en, fin_init, left, over;

  assign left = (ph_q == PH_LC) || (ph_q == PH_LF);
  assign step = ((ph_q == PH_LC) || (ph_q == PH_RC)) ? OW'(CSTEP) : OW'(1);
  assign lhi  = (cap_den && (cap_dbi > cap_dq)) ? cap_dbi : cap_dq;
  assign lim  = left ? (OW'(TAP_MAX) - {1'b0, lhi}) : (OW'(TAP_MAX) - {1'b0, cap_dqs});
  assign nxt  = off_q + step;
  assign back = off_q - step;
  assign over = nxt > lim;

  always_comb begin
    st_n = st_q;  ph_n = ph_q;  off_n = off_q;
    lc_n = lc;    lf_n = lf;    rc_n = rc;    rf_n = rf;
    err_n = err_code;
    cap_en = 1'b0;  fin_en = 1'b0;  fin_init = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_n = ST_STEP;  ph_n = PH_LC;  off_n = '0;
        lc_n = '0;  lf_n = '0;  rc_n = '0;  rf_n = '0;
        err_n = '0;  cap_en = 1'b1;
      end
      ST_STEP: if (over) begin
        st_n = ST_DONE;  err_n = ERR_BASE + {6'b0, ph_q};
        fin_en = 1'b1;   fin_init = 1'b1;
      end else begin
        off_n = nxt;  st_n = ST_REQ;
      end
      ST_REQ:  st_n = ST_WAIT;
      ST_WAIT: if (chk_ack) begin
        st_n = ST_STEP;
        if (!chk_pass) begin
          unique case (ph_q)
            PH_LC: begin lc_n = back[TW-1:0]; off_n = back; ph_n = PH_LF; end
            PH_LF: begin lf_n = back[TW-1:0]; off_n = '0;   ph_n = PH_RC; end
            PH_RC: begin rc_n = back[TW-1:0]; off_n = back; ph_n = PH_RF; end
            default: begin rf_n = back[TW-1:0]; st_n = ST_FIX; end
          endcase
        end
      end
      ST_FIX:  begin st_n = ST_DONE; fin_en = 1'b1; end
      ST_DONE: st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  ph_q <= PH_LC;  off_q <= '0;
      lc <= '0;  lf <= '0;  rc <= '0;  rf <= '0;  err_code <= '0;
    end else begin
      st_q <= st_n;  ph_q <= ph_n;  off_q <= off_n;
      lc <= lc_n;  lf <= lf_n;  rc <= rc_n;  rf <= rf_n;  err_code <= err_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_dq <= '0;  cap_dbi <= '0;  cap_dqs <= '0;  cap_den <= 1'b0;
    end else if (cap_en) begin
      cap_dq <= init_dq;  cap_dbi <= init_dbi;  cap_dqs <= init_dqs;  cap_den <= dbi_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fin_dqs <= '0;  fin_dq <= '0;  fin_dbi <= '0;
    end else if (fin_en) begin
      fin_dqs <= fin_init ? cap_dqs : fix_dqs;
      fin_dq  <= fin_init ? cap_dq  : fix_dq;
      fin_dbi <= fin_init ? cap_dbi : fix_dbi;
    end
  end

  assign st_o    = st_q;
  assign ph_o    = ph_q;
  assign off_o   = off_q[TW-1:0];
  assign chk_req = (st_q == ST_REQ);
  assign done    = (st_q == ST_DONE);
endmodule

// File: rtl/wdly_center_top.sv
// rst_n is asserted asynchronously; its release is synchronised upstream.
module wdly_center_top
  import wdly_pkg::*;
#(
  parameter int TW      = 9,
  parameter int TAP_MAX = 511,
  parameter int CSTEP   = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dbi_en,
  input  logic [TW-1:0] init_dq,
  input  logic [TW-1:0] init_dbi,
  input  logic [TW-1:0] init_dqs,
  output logic          chk_req,
  input  logic          chk_ack,
  input  logic          chk_pass,
  output logic [TW-1:0] dq_tap,
  output logic [TW-1:0] dbi_tap,
  output logic [TW-1:0] dqs_tap,
  output logic [TW-1:0] lmrg_crs,
  output logic [TW-1:0] lmrg_fin,
  output logic [TW-1:0] rmrg_crs,
  output logic [TW-1:0] rmrg_fin,
  output logic [TW-1:0] dqs_fin,
  output logic [TW-1:0] dq_fin,
  output logic [TW-1:0] dbi_fin,
  output logic          done,
  output logic [7:0]    err_code
);
  st_e           st_w;
  ph_e           ph_w;
  logic [TW-1:0] off_w, cap_dq_w, cap_dbi_w, cap_dqs_w;
  logic [TW-1:0] fx_dqs, fx_dq, fx_dbi;
  logic          cap_den_w, lphase_w, rphase_w, waiting_w;

  assign waiting_w = (st_w == ST_WAIT);

  wdly_seq #(.TW(TW), .TAP_MAX(TAP_MAX), .CSTEP(CSTEP)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .dbi_en(dbi_en),
    .init_dq(init_dq), .init_dbi(init_dbi), .init_dqs(init_dqs),
    .chk_ack(chk_ack), .chk_pass(chk_pass),
    .fix_dqs(fx_dqs), .fix_dq(fx_dq), .fix_dbi(fx_dbi),
    .st_o(st_w), .ph_o(ph_w), .off_o(off_w),
    .cap_dq(cap_dq_w), .cap_dbi(cap_dbi_w), .cap_dqs(cap_dqs_w), .cap_den(cap_den_w),
    .lc(lmrg_crs), .lf(lmrg_fin), .rc(rmrg_crs), .rf(rmrg_fin),
    .fin_dqs(dqs_fin), .fin_dq(dq_fin), .fin_dbi(dbi_fin),
    .chk_req(chk_req), .done(done), .err_code(err_code)
  );

  wdly_fix #(.TW(TW)) u_fix (
    .lf(lmrg_fin), .rf(rmrg_fin),
    .idq(cap_dq_w), .idbi(cap_dbi_w), .idqs(cap_dqs_w), .den(cap_den_w),
    .dqs_o(fx_dqs), .dq_o(fx_dq), .dbi_o(fx_dbi)
  );

  wdly_tapmux #(.TW(TW)) u_mux (
    .st(st_w), .ph(ph_w), .off(off_w),
    .cdq(cap_dq_w), .cdbi(cap_dbi_w), .cdqs(cap_dqs_w), .cden(cap_den_w),
    .fdq(dq_fin), .fdbi(dbi_fin), .fdqs(dqs_fin),
    .dq(dq_tap), .dbi(dbi_tap), .dqs(dqs_tap),
    .lphase(lphase_w), .rphase(rphase_w)
  );
endmodule

// File: rtl/wdly_center_chk.sv
module wdly_center_chk #(
  parameter int TW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chk_req,
  input logic          chk_ack,
  input logic          done,
  input logic [7:0]    err_code,
  input logic [TW-1:0] dq_tap,
  input logic [TW-1:0] dbi_tap,
  input logic [TW-1:0] dqs_tap,
  input logic [TW-1:0] dqs_fin,
  input logic          waiting,
  input logic          lphase,
  input logic          rphase,
  input logic [TW-1:0] cap_dq,
  input logic [TW-1:0] cap_dbi,
  input logic [TW-1:0] cap_dqs,
  input logic          cap_den
);
  p_req_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    chk_req |=> !chk_req);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_taps_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !chk_ack && $past(waiting)) |->
      ($stable(dq_tap) && $stable(dqs_tap) && $stable(dbi_tap)));

  p_dqs_home_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lphase |-> (dqs_tap == cap_dqs));

  p_data_home_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rphase |-> ((dq_tap == cap_dq) && (dbi_tap == cap_dbi)));

  p_dbi_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lphase && cap_den) |-> (TW'(dbi_tap - cap_dbi) == TW'(dq_tap - cap_dq)));

  p_dbi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lphase && !cap_den) |-> (dbi_tap == cap_dbi));

  p_err_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (err_code != 8'h00)) |-> ((err_code >= 8'h37) && (err_code <= 8'h3A)));

  p_dqs_not_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (err_code == 8'h00)) |-> (dqs_fin <= cap_dqs));
endmodule

bind wdly_center_top wdly_center_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .chk_req(chk_req), .chk_ack(chk_ack),
  .done(done), .err_code(err_code),
  .dq_tap(dq_tap), .dbi_tap(dbi_tap), .dqs_tap(dqs_tap), .dqs_fin(dqs_fin),
  .waiting(waiting_w), .lphase(lphase_w), .rphase(rphase_w),
  .cap_dq(cap_dq_w), .cap_dbi(cap_dbi_w), .cap_dqs(cap_dqs_w), .cap_den(cap_den_w)
);

// File: tb/wdly_center_top_tb_top.sv
`timescale 1ns/1ps
module wdly_center_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       dbi_en = 1'b0;
  logic [8:0] init_dq = '0, init_dbi = '0, init_dqs = '0;
  logic       chk_req, chk_ack = 1'b0, chk_pass = 1'b0;
  logic [8:0] dq_tap, dbi_tap, dqs_tap;
  logic [8:0] lmrg_crs, lmrg_fin, rmrg_crs, rmrg_fin;
  logic [8:0] dqs_fin, dq_fin, dbi_fin;
  logic       done;
  logic [7:0] err_code;

  int n_chk = 0, n_bad = 0;
  // eye model
  int m_lw = 0, m_rw = 0, m_gl = 9999;
  bit m_gl_used = 0;
  int viol_r4 = 0, viol_r5 = 0;

  always #2 clk = ~clk;

  wdly_center_top dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .dbi_en(dbi_en),
    .init_dq(init_dq), .init_dbi(init_dbi), .init_dqs(init_dqs),
    .chk_req(chk_req), .chk_ack(chk_ack), .chk_pass(chk_pass),
    .dq_tap(dq_tap), .dbi_tap(dbi_tap), .dqs_tap(dqs_tap),
    .lmrg_crs(lmrg_crs), .lmrg_fin(lmrg_fin), .rmrg_crs(rmrg_crs), .rmrg_fin(rmrg_fin),
    .dqs_fin(dqs_fin), .dq_fin(dq_fin), .dbi_fin(dbi_fin),
    .done(done), .err_code(err_code)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  // pattern checker model: answers two cycles after each request
  initial begin
    int cnt = 0;
    bit pp = 0;
    forever begin
      @(negedge clk);
      chk_ack = 1'b0;
      if (cnt == 1) begin chk_ack = 1'b1; chk_pass = pp; end
      if (cnt > 0) cnt--;
      if (chk_req) begin
        int s;
        bit dbi_ok;
        s = (int'(dq_tap) - int'(init_dq)) - (int'(dqs_tap) - int'(init_dqs));
        dbi_ok = dbi_en ? ((int'(dbi_tap) - int'(init_dbi)) == (int'(dq_tap) - int'(init_dq)))
                        : (dbi_tap == init_dbi);
        if (!dbi_ok) viol_r5++;
        if ((dqs_tap != init_dqs) && ((dq_tap != init_dq) || (dbi_tap != init_dbi))) viol_r4++;
        pp = (s <= m_lw) && (s >= -m_rw) && dbi_ok;
        if (s == m_gl && !m_gl_used) begin pp = 1'b0; m_gl_used = 1'b1; end
        cnt = 2;
      end
    end
  end

  task automatic run_case(input int idq, input int idbi, input int idqs, input bit den,
                          input int lw, input int rw, input int gl);
    int wd = 0;
    init_dq = 9'(idq); init_dbi = 9'(idbi); init_dqs = 9'(idqs); dbi_en = den;
    m_lw = lw; m_rw = rw; m_gl = gl; m_gl_used = 1'b0;
    viol_r4 = 0; viol_r5 = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done && wd < 20000) begin @(negedge clk); wd++; end
    chk("R9 run completes", int'(done), 1);
  endtask

  task automatic done_drops();
    @(negedge clk);
    chk("R9 done one cycle", int'(done), 0);
  endtask

  task automatic t_reset();
    chk("R1 done", int'(done), 0);
    chk("R1 chk_req", int'(chk_req), 0);
    chk("R1 err", int'(err_code), 0);
    chk("R1 taps", int'(dq_tap) + int'(dbi_tap) + int'(dqs_tap), 0);
  endtask

  task automatic t_right_wider();
    run_case(100, 120, 200, 1, 23, 57, 9999);
    chk("R9 err ok", int'(err_code), 0);
    chk("R2 lmrg_crs", int'(lmrg_crs), 20);
    chk("R3 lmrg_fin", int'(lmrg_fin), 23);
    chk("R4 rmrg_crs", int'(rmrg_crs), 50);
    chk("R4 rmrg_fin", int'(rmrg_fin), 57);
    chk("R6 dqs_fin", int'(dqs_fin), 183);
    chk("R6 dq_fin", int'(dq_fin), 100);
    chk("R6 dbi_fin", int'(dbi_fin), 120);
    chk("R6 dqs_tap", int'(dqs_tap), 183);
    chk("R4 data still", viol_r4, 0);
    chk("R5 dbi track", viol_r5, 0);
    done_drops();
  endtask

  task automatic t_left_wider();
    run_case(100, 120, 200, 1, 64, 15, 9999);
    chk("R2 lmrg_crs", int'(lmrg_crs), 60);
    chk("R3 lmrg_fin", int'(lmrg_fin), 64);
    chk("R4 rmrg_crs", int'(rmrg_crs), 10);
    chk("R4 rmrg_fin", int'(rmrg_fin), 15);
    chk("R7 dq_fin", int'(dq_fin), 124);
    chk("R7 dbi_fin", int'(dbi_fin), 144);
    chk("R7 dqs_fin", int'(dqs_fin), 200);
    chk("R5 dbi track", viol_r5, 0);
    done_drops();
  endtask

  task automatic t_dbi_off();
    run_case(100, 505, 200, 0, 41, 6, 9999);
    chk("R5 no dbi limit", int'(err_code), 0);
    chk("R7 dq_fin", int'(dq_fin), 117);
    chk("R5 dbi_fin held", int'(dbi_fin), 505);
    chk("R7 dqs_fin", int'(dqs_fin), 200);
    chk("R4 rmrg_crs", int'(rmrg_crs), 0);
    chk("R5 dbi held", viol_r5, 0);
    done_drops();
  endtask

  task automatic t_equal();
    run_case(150, 160, 170, 1, 30, 30, 9999);
    chk("R2 lmrg_crs", int'(lmrg_crs), 30);
    chk("R3 lmrg_fin", int'(lmrg_fin), 30);
    chk("R10 dqs_fin", int'(dqs_fin), 170);
    chk("R10 dq_fin", int'(dq_fin), 150);
    chk("R10 dbi_fin", int'(dbi_fin), 160);
    done_drops();
  endtask

  task automatic t_dqs_floor();
    run_case(50, 60, 5, 1, 2, 40, 9999);
    chk("R2 lmrg_crs small", int'(lmrg_crs), 0);
    chk("R3 lmrg_fin small", int'(lmrg_fin), 2);
    chk("R4 rmrg_fin", int'(rmrg_fin), 40);
    chk("R6 dqs clamp", int'(dqs_fin), 0);
    chk("R6 dq_fin", int'(dq_fin), 50);
    done_drops();
  endtask

  task automatic t_err_lc();
    run_case(100, 505, 200, 1, 100, 100, 9999);
    chk("R8 code 0x37", int'(err_code), 'h37);
    chk("R8 dq_fin init", int'(dq_fin), 100);
    chk("R8 dbi_fin init", int'(dbi_fin), 505);
    chk("R8 dq_tap init", int'(dq_tap), 100);
    done_drops();
  endtask

  task automatic t_err_lf();
    run_case(490, 0, 200, 0, 300, 50, 10);
    chk("R8 code 0x38", int'(err_code), 'h38);
    chk("R8 lmrg_crs", int'(lmrg_crs), 0);
    chk("R8 dqs_fin init", int'(dqs_fin), 200);
    done_drops();
  endtask

  task automatic t_err_rc();
    run_case(100, 100, 505, 1, 20, 100, 9999);
    chk("R8 code 0x39", int'(err_code), 'h39);
    chk("R3 lmrg_fin kept", int'(lmrg_fin), 20);
    chk("R8 dqs_fin init", int'(dqs_fin), 505);
    done_drops();
  endtask

  task automatic t_err_rf();
    run_case(100, 100, 490, 1, 20, 300, -10);
    chk("R8 code 0x3A", int'(err_code), 'h3A);
    chk("R8 rmrg_crs", int'(rmrg_crs), 0);
    chk("R8 dq_fin init", int'(dq_fin), 100);
    done_drops();
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_right_wider();
    t_left_wider();
    t_dbi_off();
    t_equal();
    t_dqs_floor();
    t_err_lc();
    t_err_lf();
    t_err_rc();
    t_err_rf();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule